// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block sits beside the loop filter of a digitally controlled clock loop. While the loop is tracking its reference and locked, the block samples the live frequency-control word once per storage period. The samples go into two slots, and the block writes the slots in turn. The storage period is a fixed number of timebase ticks.

When holdover is requested, the block latches the older of the two slots into a frozen output register. That word was captured between one and two storage periods before the request, so it predates any disturbance of the reference just before the mode change. The frozen word stays in place until the loop is back in normal mode. A valid flag tells the consumer whether the selected slot held a real sample.

The oscillator, the loop filter and the mode decisions belong to the surrounding logic. The block only stores the word and hands it back.

Top module: `hfreq_store`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `hold_valid` is 0 and `hold_word` is 0. Reset also empties both slots, sets the write pointer to slot 0 and clears the period count.
- R2: A storage strobe occurs on every PERIOD_CYCLES-th cycle in which `base_tick` is 1. Cycles with `base_tick` at 0 do not advance the count. Two strobes are never back to back.
- R3: On a strobe cycle with `locked`=1, `normal_mode`=1, `holdover_req`=0 and no holdover in progress, `freq_in` is written into the slot the write pointer names. The pointer then moves to the other slot. After reset, writes go to slot 0, then slot 1, then slot 0, and so on.
- R4: No slot is written and the write pointer keeps its value on any strobe where `locked` or `normal_mode` is 0, so the alternation resumes where it stopped.
- R5: A cycle with `holdover_req`=1 while not holding starts holdover. From the next cycle, `hold_word` equals the slot the write pointer names, which is the older of the two slots.
- R6: On holdover entry, `hold_valid` becomes 1 only if the selected slot has been written since reset; otherwise it becomes 0.
- R7: While holdover is in progress, `hold_word` does not change, whatever `freq_in`, `holdover_req` or the strobes do.
- R8: Holdover ends on a cycle with `normal_mode`=1 and `holdover_req`=0 while holding. `hold_valid` is 0 from the next cycle, and `hold_word` keeps its last value.
- R9: No slot is written in a cycle where `holdover_req` is 1 or holdover is in progress. A request that coincides with a strobe therefore latches the slot contents from before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Timebase tick; PERIOD_CYCLES of them make one storage period |
| freq_in | input | FREQ_W | Live frequency-control word from the loop |
| locked | input | 1 | Loop is locked to its reference |
| normal_mode | input | 1 | Loop is in normal tracking mode |
| holdover_req | input | 1 | Request to enter holdover |
| hold_word | output | FREQ_W | Frozen holdover frequency word |
| hold_valid | output | 1 | Frozen word came from a written slot and holdover is in progress |

## Verification
The bench aims at the pointer choice on entry. A design that returns the newest slot, or one whose pointer moves during unlocked periods, latches a word one period too young. It requests holdover exactly on a strobe cycle: a design that lets that write through freezes a value written in the same cycle. Holdover is also requested after reset, once before any write and once after a single write, which exposes a valid flag that ignores the slot-filled state. Irregular `base_tick` gaps catch a period counter that counts clocks instead of ticks. Changing `freq_in` during holdover catches an output register that is not frozen.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

    // Number of storage slots; the ping-pong scheme relies on exactly two.
    localparam int unsigned SLOT_COUNT = 2;

    typedef logic slot_sel_t;

    typedef enum logic {
        TRACKING = 1'b0,
        FROZEN   = 1'b1
    } hold_state_e;

    // Per-cycle control decisions made at the top level.
    typedef struct packed {
        logic strobe;   // storage period elapsed
        logic write;    // store freq_in into the pointed slot
        logic enter;    // start holdover
        logic leave;    // end holdover
    } hfs_ctrl_t;

    function automatic slot_sel_t next_slot(input slot_sel_t cur);
        return ~cur;
    endfunction

    // The slot due for the next write is the one written longest ago.
    function automatic slot_sel_t oldest_slot(input slot_sel_t wr_ptr);
        return wr_ptr;
    endfunction

endpackage

// File: rtl/hfs_period_timer.sv
module hfs_period_timer #(
    parameter int unsigned PERIOD_CYCLES = 26000
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    output logic strobe
);
    localparam int unsigned CNT_W = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign strobe = base_tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (base_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hfs_slot_bank.sv
module hfs_slot_bank
    import hfs_pkg::*;
#(
    parameter int unsigned FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FREQ_W-1:0] wr_data,
    output slot_sel_t         wr_ptr,
    output logic [FREQ_W-1:0] old_word,
    output logic              old_filled
);
    slot_sel_t         ptr_q;
    logic [FREQ_W-1:0] word_arr   [SLOT_COUNT];
    logic              filled_arr [SLOT_COUNT];

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        logic [FREQ_W-1:0] word_r;
        logic              filled_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_r   <= '0;
                filled_r <= 1'b0;
            end else if (wr_en && (ptr_q == slot_sel_t'(g))) begin
                word_r   <= wr_data;
                filled_r <= 1'b1;
            end
        end

        assign word_arr[g]   = word_r;
        assign filled_arr[g] = filled_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= slot_sel_t'(0);
        end else if (wr_en) begin
            ptr_q <= next_slot(ptr_q);
        end
    end

    assign wr_ptr     = ptr_q;
    assign old_word   = word_arr[oldest_slot(ptr_q)];
    assign old_filled = filled_arr[oldest_slot(ptr_q)];

endmodule

// File: rtl/hfs_hold_latch.sv
module hfs_hold_latch
    import hfs_pkg::*;
#(
    parameter int unsigned FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic              leave,
    input  logic [FREQ_W-1:0] cand_word,
    input  logic              cand_filled,
    output logic              hold_active,
    output logic [FREQ_W-1:0] hold_word,
    output logic              hold_valid
);
    hold_state_e       state_q;
    logic [FREQ_W-1:0] word_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRACKING;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (enter) begin
            state_q <= FROZEN;
            word_q  <= cand_word;
            valid_q <= cand_filled;
        end else if (leave) begin
            state_q <= TRACKING;
            valid_q <= 1'b0;
        end
    end

    assign hold_active = (state_q == FROZEN);
    assign hold_word   = word_q;
    assign hold_valid  = valid_q;

endmodule

// File: rtl/hfreq_store.sv
module hfreq_store
    import hfs_pkg::*;
#(
    parameter int unsigned FREQ_W        = 32,
    parameter int unsigned PERIOD_CYCLES = 26000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic              locked,
    input  logic              normal_mode,
    input  logic              holdover_req,
    output logic [FREQ_W-1:0] hold_word,
    output logic              hold_valid
);
    hfs_ctrl_t         ctrl;
    logic              period_strobe;
    logic              slot_wr_en;
    slot_sel_t         wr_ptr;
    logic              hold_active;
    logic [FREQ_W-1:0] old_word;
    logic              old_filled;

    hfs_period_timer #(
        .PERIOD_CYCLES(PERIOD_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .strobe   (period_strobe)
    );

    always_comb begin
        ctrl.strobe = period_strobe;
        ctrl.write  = period_strobe && locked && normal_mode && !hold_active && !holdover_req;
        ctrl.enter  = holdover_req && !hold_active;
        ctrl.leave  = hold_active && normal_mode && !holdover_req;
    end

    assign slot_wr_en = ctrl.write;

    hfs_slot_bank #(
        .FREQ_W(FREQ_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (slot_wr_en),
        .wr_data   (freq_in),
        .wr_ptr    (wr_ptr),
        .old_word  (old_word),
        .old_filled(old_filled)
    );

    hfs_hold_latch #(
        .FREQ_W(FREQ_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .enter      (ctrl.enter),
        .leave      (ctrl.leave),
        .cand_word  (old_word),
        .cand_filled(old_filled),
        .hold_active(hold_active),
        .hold_word  (hold_word),
        .hold_valid (hold_valid)
    );

endmodule

// File: rtl/hfs_store_checker.sv
module hfs_store_checker #(
    parameter int unsigned FREQ_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              locked,
    input logic              normal_mode,
    input logic              holdover_req,
    input logic [FREQ_W-1:0] hold_word,
    input logic              hold_valid,
    input logic              strobe,
    input logic              wr_en,
    input logic              wr_ptr,
    input logic              hold_active
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> !hold_valid);

    assert_strobe_spaced_R2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    assert_ptr_toggles_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_ptr != $past(wr_ptr)));

    assert_ptr_kept_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_ptr));

    assert_no_write_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !locked) |-> !wr_en);

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        hold_active |=> $stable(hold_word));

    assert_exit_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (hold_active && normal_mode && !holdover_req) |=> !hold_valid);

    assert_no_write_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_active || holdover_req) |-> !wr_en);

endmodule

bind hfreq_store hfs_store_checker #(
    .FREQ_W(FREQ_W)
) u_store_chk (
    .clk         (clk),
    .rst         (rst),
    .locked      (locked),
    .normal_mode (normal_mode),
    .holdover_req(holdover_req),
    .hold_word   (hold_word),
    .hold_valid  (hold_valid),
    .strobe      (period_strobe),
    .wr_en       (slot_wr_en),
    .wr_ptr      (wr_ptr),
    .hold_active (hold_active)
);

// File: tb/hfreq_store_test.sv
module hfreq_store_test;
    localparam int W = 32;
    localparam int P = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         base_tick = 1'b0;
    logic         locked = 1'b0;
    logic         normal_mode = 1'b0;
    logic         holdover_req = 1'b0;
    logic [W-1:0] freq_in = '0;
    logic [W-1:0] hold_word;
    logic         hold_valid;

    always #4 clk = ~clk;   // 125 MHz

    hfreq_store #(.FREQ_W(W), .PERIOD_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .freq_in(freq_in),
        .locked(locked), .normal_mode(normal_mode), .holdover_req(holdover_req),
        .hold_word(hold_word), .hold_valid(hold_valid)
    );

    typedef struct {
        logic [W-1:0] word;
        logic         valid;
        int           due;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference state, derived from the requirements.
    int           m_cnt;
    bit           m_ptr;
    logic [W-1:0] m_slot [2];
    bit           m_filled [2];
    bit           m_hold;
    logic [W-1:0] m_word;
    bit           m_valid;
    int           seq = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(string tag, logic [W-1:0] aw, logic av, logic [W-1:0] ew, logic ev);
        checks++;
        if (aw !== ew || av !== ev) begin
            errors++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b", tag, aw, av, ew, ev);
        end
    endtask

    // Monitor: pops expectations once their cycle has come.
    always @(negedge clk) begin
        exp_t e;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            e = exp_q.pop_front();
            compare(e.tag, hold_word, hold_valid, e.word, e.valid);
        end
    end

    task automatic model_reset();
        m_cnt = 0; m_ptr = 1'b0; m_hold = 1'b0; m_word = '0; m_valid = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_slot[i] = '0;
            m_filled[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        rst = 1'b1; holdover_req = 1'b0; base_tick = 1'b0;
        exp_q.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1 during reset", hold_word, hold_valid, '0, 1'b0);
        rst = 1'b0;
        model_reset();
        // First cycle after reset with idle inputs.
        e.word = '0; e.valid = 1'b0; e.due = cyc + 1; e.tag = "R1 after reset";
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Driver: one cycle of stimulus, called at a falling edge.
    task automatic step(bit bt, bit lk, bit nm, bit req, string tag);
        exp_t e;
        bit   strobe, wr, enter, leave;
        logic [W-1:0] din;
        seq++;
        din = 32'hA500_0000 + 32'(seq * 17);
        base_tick = bt; locked = lk; normal_mode = nm; holdover_req = req; freq_in = din;
        strobe = bt && (m_cnt == P - 1);
        if (bt) m_cnt = strobe ? 0 : m_cnt + 1;
        wr    = strobe && lk && nm && !m_hold && !req;
        enter = req && !m_hold;
        leave = m_hold && nm && !req;
        if (enter) begin
            m_hold = 1'b1; m_word = m_slot[m_ptr]; m_valid = m_filled[m_ptr];
        end else if (leave) begin
            m_hold = 1'b0; m_valid = 1'b0;
        end
        if (wr) begin
            m_slot[m_ptr] = din; m_filled[m_ptr] = 1'b1; m_ptr = ~m_ptr;
        end
        e.word = m_word; e.valid = m_valid; e.due = cyc + 1; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_to_strobe(string tag);
        while (m_cnt != P - 1) step(1, 1, 1, 0, tag);
    endtask

    initial begin
        model_reset();
        do_reset();

        // Holdover before any write: slot empty.
        step(1, 1, 0, 1, "R6 empty slot entry");
        step(1, 1, 0, 0, "R7 hold steady");
        step(1, 1, 0, 1, "R7 repeated request");
        step(1, 1, 1, 0, "R8 exit");
        step(1, 1, 1, 0, "R8 after exit");

        // Locked tracking with irregular ticks.
        for (int i = 0; i < 15; i++) step(i % 3 != 2, 1, 1, 0, "R2 tick gaps / R3 writes");
        step(1, 1, 0, 1, "R5 older slot on entry");
        for (int i = 0; i < 9; i++) step(1, 1, 0, i % 2, "R7 frozen while holding");
        step(1, 1, 1, 0, "R8 exit");
        for (int i = 0; i < 9; i++) step(1, 1, 1, 0, "R3 alternate writes");

        // Unlocked, then not in normal mode: no writes.
        for (int i = 0; i < 10; i++) step(1, 0, 1, 0, "R4 unlocked");
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R4 not normal");
        step(1, 1, 0, 1, "R4 entry after pause");
        step(1, 1, 1, 0, "R8 exit");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0, "R4 resume alternation");
        step(1, 1, 0, 1, "R4 entry after resume");
        step(1, 1, 1, 0, "R8 exit");

        // Request coinciding with a strobe.
        run_to_strobe("R3 approach strobe");
        step(1, 1, 1, 1, "R9 request on strobe");
        step(1, 1, 0, 0, "R7 hold");
        step(1, 1, 1, 0, "R8 exit");
        for (int i = 0; i < 9; i++) step(1, 1, 1, 0, "R3 writes");
        step(1, 1, 0, 1, "R5 older slot on entry");
        step(1, 1, 1, 0, "R8 exit");

        // Only one write since reset: older slot still empty.
        do_reset();
        run_to_strobe("R2 first period");
        step(1, 1, 1, 0, "R3 first write");
        step(1, 1, 0, 1, "R6 older slot empty");
        step(1, 1, 1, 0, "R8 exit");
        run_to_strobe("R2 second period");
        step(1, 1, 1, 0, "R3 second write");
        step(1, 1, 0, 1, "R6 older slot filled");
        step(1, 1, 1, 0, "R8 exit");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule